// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit does byte-wide packed BCD arithmetic. Each byte holds two decimal digits. The unit supports three operations, and each one folds in an incoming extend bit:

- **Add:** destination plus source.
- **Subtract:** source taken from destination.
- **Negate:** destination taken from zero.

Decode logic outside the unit supplies the operands and the current extend and zero flags. Decode logic also writes the result back. Operand fetch is not part of the unit.

The zero flag is never set by the unit; it can only be cleared. A result of zero passes the incoming zero flag through unchanged. This lets software chain the unit byte by byte across a long decimal string, with the extend bit carrying between bytes. At the end, the zero flag reports whether the whole string is zero.

The datapath is combinational. The `OUT_REG` parameter adds an output register stage, and it is on by default.

Top module: `bcd_unit`

## Requirements
- R1: With `op_i`=2'b00 the result is the decimal sum dst+src+x_i modulo 100. The carry is 1 when that sum exceeds 99.
- R2: With `op_i`=2'b01 the result is dst−src−x_i modulo 100. The borrow is 1 when that difference is below zero.
- R3: When `op_i[1]`=1 the result is 0−dst−x_i modulo 100. The borrow is 1 in every case except dst=0 with x_i=0.
- R4: When `op_i[1]`=1, `src_i` has no effect on any output. This applies to both 2'b10 and 2'b11.
- R5: `x_o` and `c_o` both carry the decimal carry for add, or the decimal borrow for subtract and negate.
- R6: `z_o` is 0 when the result byte is nonzero. When the result byte is zero, `z_o` equals `z_i`.
- R7: `n_o` equals result bit 7, and `v_o` is always 0.
- R8: Digits are corrected one at a time, starting from the low digit. The carry-in of the low digit is x_i. Each digit is defined as follows:
  - For add, compute t=a+b+cin. If t>9, the digit is (t+6) mod 16 and the carry out is 1. Otherwise the digit is t and the carry out is 0.
  - For subtract, compute t=a−b−bin. If t<0, the digit is (t−6) mod 16 and the borrow out is 1. Otherwise the digit is t and the borrow out is 0.
  - Negate uses a=0 and b=dst.
  - This rule also defines the outputs for nibbles A–F.
- R9: With `OUT_REG`=1, the outputs show each input set one clock after it is applied. An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | 00 add, 01 subtract, 1x negate |
| dst_i | input | 8 | Destination operand, two BCD digits |
| src_i | input | 8 | Source operand, two BCD digits |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag |
| res_o | output | 8 | Result byte |
| x_o | output | 1 | Extend out |
| c_o | output | 1 | Carry/borrow out |
| z_o | output | 1 | Zero flag out (can only clear) |
| n_o | output | 1 | Result bit 7 |
| v_o | output | 1 | Always 0 |

## Verification
The unit holds no state between operations. Any fault in a digit stage therefore shows at the ports one cycle after the stimulus that triggers it:

- A wrong correction shows as a non-decimal digit, or as a digit that is off by six.
- A broken carry chain shows as a wrong high digit or a wrong `x_o`/`c_o`.
- A zero flag that sets when it should only clear shows as `z_o`=1 while `z_i`=0.

The bench compares every output on every clock against a decimal model for valid operands and the digit-rule model for A–F nibbles. Stimulus covers the wrap cases at 99 and 00, the extend input used as carry and as borrow, and negation from zero.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIG_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_NGX = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic c;
    logic z;
    logic n;
    logic v;
  } bcd_flags_t;
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_pkg::*;
(
  input  logic [DIG_W-1:0] a_i,
  input  logic [DIG_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] r_o,
  output logic             cout_o
);
  logic signed [DIG_W+1:0] t;

  always_comb begin
    if (sub_i) begin
      t = $signed({2'b00, a_i}) - $signed({2'b00, b_i}) - $signed({{(DIG_W+1){1'b0}}, cin_i});
      cout_o = t[DIG_W+1];
      r_o    = cout_o ? (t[DIG_W-1:0] - 4'd6) : t[DIG_W-1:0];
    end else begin
      t = $signed({2'b00, a_i}) + $signed({2'b00, b_i}) + $signed({{(DIG_W+1){1'b0}}, cin_i});
      cout_o = (t > 6'sd9);
      r_o    = cout_o ? (t[DIG_W-1:0] + 4'd6) : t[DIG_W-1:0];
    end
  end

  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9)
      AST_DIGIT_RANGE: assert (r_o <= 4'd9); // R1
  end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = DIGITS * DIG_W
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         x_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic         neg, sub;
  logic [W-1:0] opa, opb;
  logic [DIGITS:0] cy;

  assign neg   = op_i[1];
  assign sub   = (op_i != OP_ADD);
  assign opa   = neg ? '0 : dst_i;
  assign opb   = neg ? dst_i : src_i;
  assign cy[0] = x_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit u_dig (
      .a_i   (opa[g*DIG_W +: DIG_W]),
      .b_i   (opb[g*DIG_W +: DIG_W]),
      .sub_i (sub),
      .cin_i (cy[g]),
      .r_o   (res_o[g*DIG_W +: DIG_W]),
      .cout_o(cy[g+1])
    );
  end

  assign cout_o = cy[DIGITS];

  always_comb begin
    if (op_i == OP_SUB && dst_i == src_i && x_i == 1'b0)
      AST_SUB_SELF: assert (res_o == '0 && !cout_o); // R2
    if (op_i[1] == 1'b1 && dst_i == '0 && x_i == 1'b0)
      AST_NEG_ZERO: assert (res_o == '0 && !cout_o); // R3
  end
endmodule

// File: rtl/bcd_unit.sv
module bcd_unit
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS  = 2,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned W = DIGITS * DIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         x_i,
  input  logic         z_i,
  output logic [W-1:0] res_o,
  output logic         x_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o
);
  logic [W-1:0] res_d;
  logic         cy_d;
  bcd_flags_t   fl_d, fl_q;
  logic [W-1:0] res_q;

  bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .op_i  (op_i),
    .dst_i (dst_i),
    .src_i (src_i),
    .x_i   (x_i),
    .res_o (res_d),
    .cout_o(cy_d)
  );

  always_comb begin
    fl_d.x = cy_d;
    fl_d.c = cy_d;
    fl_d.z = z_i & (res_d == '0);  // sticky: only clears
    fl_d.n = res_d[W-1];
    fl_d.v = 1'b0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        fl_q  <= '0;
      end else begin
        res_q <= res_d;
        fl_q  <= fl_d;
      end
    end

    AST_Z_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !z_i |=> !z_o); // R6
    AST_Z_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_o != '0) |-> !z_o); // R6
  end else begin : g_comb
    assign res_q = res_d;
    assign fl_q  = fl_d;
  end

  assign res_o = res_q;
  assign x_o   = fl_q.x;
  assign c_o   = fl_q.c;
  assign z_o   = fl_q.z;
  assign n_o   = fl_q.n;
  assign v_o   = fl_q.v;
endmodule

// File: tb/tb_bcd_unit.sv
module tb_bcd_unit;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] dst_i = 8'h00, src_i = 8'h00;
  logic       x_i = 1'b0, z_i = 1'b0;
  logic [7:0] res_o;
  logic       x_o, c_o, z_o, n_o, v_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  bcd_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .x_i(x_i), .z_i(z_i), .res_o(res_o), .x_o(x_o), .c_o(c_o), .z_o(z_o),
    .n_o(n_o), .v_o(v_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_dec(input int v);
    return ((v & 15) <= 9) && (((v >> 4) & 15) <= 9);
  endfunction

  function automatic int dec(input int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  // R8 digit rule; R1/R2/R3 decimal model for valid operands
  function automatic void model(input int op, input int d, input int s, input int x,
                                output int res, output int cy);
    int a, b, c, t, dig, v;
    bit neg, sub;
    neg = op[1];
    sub = (op != 0);
    a = neg ? 0 : d;
    b = neg ? d : s;
    if (is_dec(a) && is_dec(b)) begin
      v = sub ? dec(a) - dec(b) - x : dec(a) + dec(b) + x;
      cy = sub ? (v < 0) : (v > 99);
      v = (v + 100) % 100;
      res = ((v / 10) << 4) | (v % 10);
    end else begin
      c = x;
      res = 0;
      for (int i = 0; i < 2; i++) begin
        t = sub ? ((a >> (4*i)) & 15) - ((b >> (4*i)) & 15) - c
                : ((a >> (4*i)) & 15) + ((b >> (4*i)) & 15) + c;
        if (!sub && t > 9) begin dig = (t + 6) % 16; c = 1; end
        else if (sub && t < 0) begin dig = (t - 6 + 32) % 16; c = 1; end
        else begin dig = t; c = 0; end
        res |= dig << (4*i);
      end
      cy = c;
    end
  endfunction

  task automatic step(input int op, input int d, input int s, input int x,
                      input int z, input string req);
    int er, ec, ez;
    @(negedge clk_i);
    op_i = op[1:0]; dst_i = d[7:0]; src_i = s[7:0]; x_i = x[0]; z_i = z[0];
    model(op, d, s, x, er, ec);
    ez = (er == 0) ? z : 0;
    @(posedge clk_i);
    #1;
    chk(res_o == er[7:0], req, "res", int'(res_o), er);
    chk(x_o == ec[0], "R5", "x", int'(x_o), ec);
    chk(c_o == ec[0], "R5", "c", int'(c_o), ec);
    chk(z_o == ez[0], "R6", "z", int'(z_o), ez);
    chk(n_o == er[7], "R7", "n", int'(n_o), er >> 7);
    chk(v_o == 1'b0, "R7", "v", int'(v_o), 0);
  endtask

  initial begin
    int r0, c0, sd;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(res_o == 8'h00 && {x_o, c_o, z_o, n_o, v_o} == 5'b0, "R9", "reset",
        int'({res_o, x_o, c_o, z_o, n_o, v_o}), 0);
    rst_ni = 1'b1;
    // R9: one-cycle latency — output before edge is still prior value
    @(negedge clk_i);
    op_i = 2'b00; dst_i = 8'h12; src_i = 8'h34; x_i = 1'b0; z_i = 1'b0;
    #1 chk(res_o == 8'h00, "R9", "pre-edge", int'(res_o), 0);
    @(posedge clk_i); #1 chk(res_o == 8'h46, "R9", "post-edge", int'(res_o), 'h46);

    step(0, 'h45, 'h38, 0, 1, "R1");
    step(0, 'h99, 'h99, 1, 1, "R1");
    step(0, 'h50, 'h50, 0, 1, "R1");   // zero result keeps z (R6)
    step(0, 'h50, 'h50, 0, 0, "R6");
    step(0, 'h09, 'h00, 1, 1, "R1");
    step(1, 'h42, 'h17, 0, 1, "R2");
    step(1, 'h00, 'h01, 0, 1, "R2");
    step(1, 'h55, 'h55, 0, 0, "R2");
    step(1, 'h55, 'h54, 1, 1, "R2");
    step(1, 'h10, 'h00, 1, 1, "R2");
    step(2, 'h00, 'h77, 0, 1, "R3");
    step(2, 'h00, 'h00, 1, 1, "R3");
    step(2, 'h25, 'h00, 0, 1, "R3");
    step(2, 'h99, 'h00, 1, 0, "R3");
    // R4: src ignored under negate, both encodings
    model(2, 'h25, 0, 0, r0, c0);
    step(3, 'h25, 'hFF, 0, 1, "R4");
    step(2, 'h25, 'h3C, 0, 1, "R4");
    step(3, 'h00, 'hA5, 0, 1, "R4");
    // R8: non-decimal nibbles
    step(0, 'hAB, 'hCD, 0, 1, "R8");
    step(0, 'hFF, 'hFF, 1, 1, "R8");
    step(1, 'hF0, 'h0A, 0, 1, "R8");
    step(1, 'h0A, 'hF0, 1, 1, "R8");
    step(2, 'hFA, 'h00, 1, 1, "R8");
    // mixed sweep
    sd = 7;
    for (int i = 0; i < 300; i++) begin
      sd = (sd * 1103515245 + 12345) & 32'h7fffffff;
      step((sd >> 3) % 3, (sd >> 8) & 'hFF, (sd >> 16) & 'hFF, (sd >> 5) & 1,
           (sd >> 6) & 1, "R8");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule